// File: doc/BRIEF.md
# Card Clock Divider With Update Handshake

This block produces the clock that a memory-card host drives to the card, derived from the host's reference clock. Software programs a divider value and an enable bit through a small register interface. Those writes are only staged: the running clock keeps its old setting until software issues an update command, and that command is a write to the command register with the start bit and the update-only bit both set. Nothing is sent to the card for such a command. The block applies the staged setting a fixed number of cycles later, and only then does the start bit clear.

An update command may ask to wait for the data path. The block then holds the command while the data-busy input is high. A second command written while the start bit is still set is dropped, and a locked-out error flag is set in the raw interrupt register, where software clears it by writing 1. The divided clock only switches to a new setting at the end of a complete low phase, so a change never produces a shortened pulse.

Register map (3-bit word address): 0 divider (bits 7:0), 1 enable (bit 0), 2 command (write: bit 31 start, bit 21 update-only, bit 13 wait-for-data; read: bit 31 start still set), 3 raw interrupt (bit 12 locked-out error). Unmapped addresses read as 0.

Top module: `card_clk_gen`

## Requirements
- R1: After reset all four registers read 0, the card clock is low and the pending flag is low.
- R2: Writes to the divider and enable registers read back at once but leave the card clock unchanged until an update command commits them.
- R3: A write to the command register with bit 31 set makes the start bit (command register bit 31, and the pending output) read 1 for exactly two cycles when not held, then clear.
- R4: With divider value N greater than 0 and enable 1, the card clock is high for N reference cycles and low for N reference cycles, starting one cycle after the start bit clears when the clock was stopped.
- R5: With divider value 0 and enable 1, the card clock passes the reference clock straight through.
- R6: With enable 0 committed, the card clock stays low.
- R7: A new divider or enable setting takes effect only at the end of a complete low phase, so every high and low run has the length of either the old or the new divider.
- R8: With bit 13 set in the command, the start bit stays set and nothing is committed while data_busy is high; it clears two cycles after data_busy falls. Without bit 13, data_busy has no effect.
- R9: A command write with bit 31 set while the start bit is still set sets bit 12 of the raw interrupt register and is discarded, while the earlier command completes on its own schedule.
- R10: Writing 1 to bit 12 of the raw interrupt register clears the error flag; writing 0 there leaves it set.
- R11: A command with bit 31 set but bit 21 clear runs the start-bit handshake but commits no staged setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| data_busy | input | 1 | Data path busy indication |
| card_clk | output | 1 | Gated, divided card clock |
| upd_pending | output | 1 | Start bit of the command register |

## Verification
The start bit is set from the edge that captures the command write and clears two edges later, so the bench reads it right after the write, after one more cycle and after a second cycle. The divided clock leaves a stopped state on the edge after the commit, so period checks begin one cycle after the start bit clears and compare each sample against N cycles high and N cycles low. Every input is driven and every output sampled 5 ns after a rising edge, and bypass is confirmed by sampling again at mid-low phase. The glitch check does not depend on the commit phase: it measures every complete run of the clock around a divider change and accepts only the old or the new length.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int DIV_W  = 8;

    localparam logic [ADDR_W-1:0] A_DIV = 3'd0;
    localparam logic [ADDR_W-1:0] A_ENA = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMD = 3'd2;
    localparam logic [ADDR_W-1:0] A_IRQ = 3'd3;

    localparam int B_START = 31;
    localparam int B_UPD   = 21;
    localparam int B_WAIT  = 13;
    localparam int B_LOCK  = 12;

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] div;
    } clk_cfg_t;

    typedef enum logic [1:0] {
        UPD_IDLE  = 2'd0,
        UPD_HOLD  = 2'd1,
        UPD_APPLY = 2'd2
    } upd_state_t;

    function automatic logic cfg_divided(clk_cfg_t c);
        return c.en && (c.div != '0);
    endfunction

    function automatic logic cfg_bypass(clk_cfg_t c);
        return c.en && (c.div == '0);
    endfunction
endpackage

// File: rtl/ccd_regs.sv
module ccd_regs
    import ccd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pending,
    output logic [DATA_W-1:0] rdata,
    output clk_cfg_t          staged,
    output logic              cmd_go,
    output logic              cmd_upd,
    output logic              cmd_wait,
    output logic              lock_err
);
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    assign cmd_go   = wr && (addr == A_CMD) && wdata[B_START];
    assign cmd_upd  = wdata[B_UPD];
    assign cmd_wait = wdata[B_WAIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            staged   <= '0;
            lock_err <= 1'b0;
        end else begin
            if (wr && addr == A_DIV) staged.div <= wdata[DIV_W-1:0];
            if (wr && addr == A_ENA) staged.en  <= wdata[0];
            if (wr && addr == A_IRQ && wdata[B_LOCK]) lock_err <= 1'b0;
            if (cmd_go && pending) lock_err <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_DIV:   rdata[DIV_W-1:0] = staged.div;
            A_ENA:   rdata[0]         = staged.en;
            A_CMD:   rdata[B_START]   = pending;
            A_IRQ:   rdata[B_LOCK]    = lock_err;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/ccd_update.sv
module ccd_update
    import ccd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     go,
    input  logic     upd,
    input  logic     wait_data,
    input  logic     data_busy,
    input  clk_cfg_t staged,
    output logic     pending,
    output clk_cfg_t cfg_q
);
    upd_state_t state;
    logic       upd_q;
    logic       wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= UPD_IDLE;
            upd_q  <= 1'b0;
            wait_q <= 1'b0;
            cfg_q  <= '0;
        end else begin
            case (state)
                UPD_IDLE: if (go) begin
                    state  <= UPD_HOLD;
                    upd_q  <= upd;
                    wait_q <= wait_data;
                end
                UPD_HOLD: if (!(wait_q && data_busy)) state <= UPD_APPLY;
                UPD_APPLY: begin
                    if (upd_q) cfg_q <= staged;
                    state <= UPD_IDLE;
                end
                default: state <= UPD_IDLE;
            endcase
        end
    end

    assign pending = (state != UPD_IDLE);
endmodule

// File: rtl/ccd_gen.sv
module ccd_gen
    import ccd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_cfg_t cfg,
    output clk_cfg_t act,
    output logic     q,
    output logic     clk_out
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;
    logic             last;
    logic             swap_ok;

    assign last    = (cnt == act.div - ONE);
    assign swap_ok = !q && (!cfg_divided(act) || last);

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= '0;
            cnt <= '0;
            q   <= 1'b0;
        end else if (swap_ok) begin
            act <= cfg;
            cnt <= '0;
            q   <= cfg_divided(cfg);
        end else if (cfg_divided(act)) begin
            if (last) begin
                cnt <= '0;
                q   <= ~q;
            end else begin
                cnt <= cnt + ONE;
            end
        end
    end

    assign clk_out = cfg_bypass(act) ? clk : q;
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
    import ccd_pkg::*;
(
    input  logic              clk_ref,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              data_busy,
    output logic              card_clk,
    output logic              upd_pending
);
    clk_cfg_t staged;
    clk_cfg_t cfg_c;
    clk_cfg_t act;
    logic     cmd_go;
    logic     cmd_upd;
    logic     cmd_wait;
    logic     lock_err;
    logic     div_q;

    ccd_regs u_regs (
        .clk      (clk_ref),
        .rst      (rst),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .pending  (upd_pending),
        .rdata    (bus_rdata),
        .staged   (staged),
        .cmd_go   (cmd_go),
        .cmd_upd  (cmd_upd),
        .cmd_wait (cmd_wait),
        .lock_err (lock_err)
    );

    ccd_update u_upd (
        .clk       (clk_ref),
        .rst       (rst),
        .go        (cmd_go),
        .upd       (cmd_upd),
        .wait_data (cmd_wait),
        .data_busy (data_busy),
        .staged    (staged),
        .pending   (upd_pending),
        .cfg_q     (cfg_c)
    );

    ccd_gen u_gen (
        .clk     (clk_ref),
        .rst     (rst),
        .cfg     (cfg_c),
        .act     (act),
        .q       (div_q),
        .clk_out (card_clk)
    );
endmodule

// File: rtl/ccd_chk.sv
module ccd_chk
    import ccd_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     cmd_go,
    input logic     pending,
    input logic     lock_err,
    input clk_cfg_t cfg_c,
    input clk_cfg_t act,
    input logic     div_q,
    input logic     card_clk
);
    AST_START_MIN_TWO: assert property (@(posedge clk) disable iff (rst)
        $fell(pending) |-> $past(pending, 2)); // R3

    AST_LOCK_ON_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        (cmd_go && pending) |=> lock_err); // R9

    AST_COMMIT_AT_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_c) |-> $past(pending)); // R2

    AST_SWAP_IN_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(act) |-> !$past(div_q)); // R7

    AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (rst)
        !act.en |-> !card_clk); // R6
endmodule

bind card_clk_gen ccd_chk u_chk (
    .clk      (clk_ref),
    .rst      (rst),
    .cmd_go   (cmd_go),
    .pending  (upd_pending),
    .lock_err (lock_err),
    .cfg_c    (cfg_c),
    .act      (act),
    .div_q    (div_q),
    .card_clk (card_clk)
);

// File: tb/sim_card_clk_gen.sv
`timescale 1ns/1ps
module sim_card_clk_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        data_busy = 1'b0;
    logic        card_clk;
    logic        upd_pending;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    localparam logic [31:0] START = 32'h8000_0000;
    localparam logic [31:0] UPD   = 32'h0020_0000;
    localparam logic [31:0] WAITD = 32'h0000_2000;
    localparam logic [31:0] LOCK  = 32'h0000_1000;

    always #10 clk = ~clk;

    card_clk_gen u0 (
        .clk_ref(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .data_busy(data_busy),
        .card_clk(card_clk), .upd_pending(upd_pending)
    );

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check(card_clk == 1'b0, "R1 card_clk", 32'(card_clk), 0);
        check(upd_pending == 1'b0, "R1 pending", 32'(upd_pending), 0);
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), d);
            check(d == 0, "R1 register", d, 0);
        end
    endtask

    task automatic t_stage();
        logic [31:0] d;
        wr(3'd0, 32'd3);
        wr(3'd1, 32'd1);
        rd(3'd0, d); check(d == 3, "R2 divider readback", d, 3);
        rd(3'd1, d); check(d == 1, "R2 enable readback", d, 1);
        for (int i = 0; i < 8; i++) begin
            tick();
            check(card_clk == 1'b0, "R2 staged only", 32'(card_clk), 0);
        end
    endtask

    task automatic t_commit();
        logic [31:0] d;
        wr(3'd2, START | UPD);
        rd(3'd2, d); check(d[31] == 1'b1, "R3 start set", d, START);
        tick(); check(upd_pending == 1'b1, "R3 start second cycle", 32'(upd_pending), 1);
        tick(); check(upd_pending == 1'b0, "R3 start cleared", 32'(upd_pending), 0);
        tick();
        for (int k = 0; k < 12; k++) begin
            logic e;
            e = ((k / 3) % 2) == 0;
            check(card_clk == e, "R4 divide by 3 phase", 32'(card_clk), 32'(e));
            tick();
        end
    endtask

    task automatic t_runt();
        logic prev;
        bit started, got5;
        int len;
        wr(3'd0, 32'd5);
        wr(3'd2, START | UPD);
        prev = card_clk; started = 0; got5 = 0; len = 0;
        for (int i = 0; i < 50; i++) begin
            tick();
            if (card_clk != prev) begin
                if (started)
                    check(len == 3 || len == 5, "R7 run length", 32'(len), 5);
                if (started && len == 5) got5 = 1;
                started = 1; len = 1; prev = card_clk;
            end else begin
                len++;
            end
        end
        check(got5, "R7 new divider reached", 32'(got5), 1);
    endtask

    task automatic t_bypass();
        wr(3'd0, 32'd0);
        wr(3'd2, START | UPD);
        for (int i = 0; i < 16; i++) tick();
        for (int i = 0; i < 3; i++) begin
            check(card_clk == 1'b1, "R5 bypass high", 32'(card_clk), 1);
            #10;
            check(card_clk == 1'b0, "R5 bypass low", 32'(card_clk), 0);
            tick();
        end
    endtask

    task automatic t_stop();
        wr(3'd1, 32'd0);
        wr(3'd2, START | UPD);
        for (int i = 0; i < 4; i++) tick();
        for (int i = 0; i < 3; i++) begin
            check(card_clk == 1'b0, "R6 stopped high phase", 32'(card_clk), 0);
            #10;
            check(card_clk == 1'b0, "R6 stopped low phase", 32'(card_clk), 0);
            tick();
        end
    endtask

    task automatic t_wait();
        wr(3'd0, 32'd2);
        wr(3'd1, 32'd1);
        data_busy = 1'b1;
        wr(3'd2, START | UPD | WAITD);
        for (int i = 0; i < 6; i++) begin
            tick();
            check(upd_pending == 1'b1, "R8 held while busy", 32'(upd_pending), 1);
            check(card_clk == 1'b0, "R8 nothing committed", 32'(card_clk), 0);
        end
        data_busy = 1'b0;
        tick(); check(upd_pending == 1'b1, "R8 one cycle after busy", 32'(upd_pending), 1);
        tick(); check(upd_pending == 1'b0, "R8 cleared after busy", 32'(upd_pending), 0);
        tick(); check(card_clk == 1'b1, "R8 clock after commit", 32'(card_clk), 1);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        for (int i = 0; i < 4; i++) tick();
        data_busy = 1'b1;
        wr(3'd2, START | UPD);
        wr(3'd2, START | UPD | WAITD);
        rd(3'd3, d); check(d == LOCK, "R9 lock error set", d, LOCK);
        tick(); check(upd_pending == 1'b0, "R9 first done, second dropped", 32'(upd_pending), 0);
        for (int i = 0; i < 3; i++) tick();
        check(upd_pending == 1'b0, "R8 busy ignored without wait bit", 32'(upd_pending), 0);
        data_busy = 1'b0;
        wr(3'd3, 32'd0);
        rd(3'd3, d); check(d == LOCK, "R10 write 0 keeps flag", d, LOCK);
        wr(3'd3, LOCK);
        rd(3'd3, d); check(d == 0, "R10 write 1 clears flag", d, 0);
    endtask

    task automatic t_noupd();
        logic [31:0] d;
        bit saw_low;
        wr(3'd0, 32'd0);
        wr(3'd2, START);
        check(upd_pending == 1'b1, "R11 start set", 32'(upd_pending), 1);
        tick(); tick();
        check(upd_pending == 1'b0, "R11 start cleared", 32'(upd_pending), 0);
        saw_low = 0;
        for (int i = 0; i < 8; i++) begin
            tick();
            if (card_clk == 1'b0) saw_low = 1;
        end
        check(saw_low, "R11 still divided, not bypass", 32'(saw_low), 1);
        rd(3'd0, d); check(d == 0, "R11 staged divider kept", d, 0);
    endtask

    initial begin
        tick(); tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_stage();
        t_commit();
        t_runt();
        t_bypass();
        t_stop();
        t_wait();
        t_lock();
        t_noupd();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule